// File: doc/BRIEF.md
# UART FIFO Interrupt Status Capture

This block watches the strobes and occupancy flags of a UART's transmit and receive FIFOs and of its receive shift path. It turns selected transitions into sticky event bits in a six-bit status register. The FIFOs, the baud generator and the serial shifters are outside the block: it only observes them. Each event bit latches on an edge-qualified condition, not on a level, and stays set until software writes a one to it.

A small register port gives access to two registers: the status register and a six-bit enable mask. A single interrupt line is raised while any status bit is both set and enabled. Full and empty events compare the flag value seen after a push or pop with the value registered on the previous cycle. A FIFO that stays full or stays empty therefore raises its event only once per transition.

Top module: `uart_evt_irq`

## Requirements
- R1: After reset the status register, the mask register and `irq` are all 0.
- R2: The status register is read and written at address 0. Bit 5 is receive overflow, bit 4 TX full, bit 3 TX empty, bit 2 RX full, bit 1 RX empty and bit 0 RX trigger. A write with a 1 in a bit position clears that bit, a 0 leaves it as it was, and no bit ever clears without such a write.
- R3: Bit 5 sets in the cycle after `rx_start` is high while `rx_shift_pending` is high.
- R4: Bit 4 sets after a cycle in which `tx_push` is high, `tx_full` is high and `tx_full` was low in the previous cycle. A push while `tx_full` stays high does not set it.
- R5: Bit 3 sets after a cycle in which `tx_pop` is high, `tx_empty` is high and `tx_empty` was low in the previous cycle. The registered previous value resets to 1.
- R6: Bit 2 sets after a cycle in which `rx_push` is high, `rx_full` is high and `rx_full` was low in the previous cycle.
- R7: Bit 1 sets after a cycle in which `rx_pop` is high, `rx_empty` is high and `rx_empty` was low in the previous cycle. The registered previous value resets to 1.
- R8: Bit 0 sets after every cycle in which `rx_push` is high.
- R9: When a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R10: The mask register is read and written at address 1, and a write replaces it whole. `irq` is the OR of `status & mask`, where a mask bit of 1 enables its event. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Word written into the transmit FIFO this cycle |
| tx_pop | input | 1 | Word removed from the transmit FIFO this cycle |
| tx_full | input | 1 | Transmit FIFO full, value after this cycle's push or pop |
| tx_empty | input | 1 | Transmit FIFO empty, value after this cycle's push or pop |
| rx_push | input | 1 | Word written into the receive FIFO this cycle |
| rx_pop | input | 1 | Word removed from the receive FIFO this cycle |
| rx_full | input | 1 | Receive FIFO full, value after this cycle's push or pop |
| rx_empty | input | 1 | Receive FIFO empty, value after this cycle's push or pop |
| rx_start | input | 1 | Receiver detected a new start bit |
| rx_shift_pending | input | 1 | Receive shift register holds a word not yet moved to the FIFO |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | AW | Register write address |
| reg_wdata | input | 6 | Register write data |
| reg_raddr | input | AW | Register read address |
| reg_rdata | output | 6 | Register read data, combinational from `reg_raddr` |
| irq | output | 1 | Combined interrupt: any set and enabled status bit |

## Verification
The bench builds the block with its defaults: a two-bit address with status at 0 and mask at 1. This leaves addresses 2 and 3 unmapped, so random reads and writes also reach the decode paths that must return 0 and must leave both registers alone. Random flag levels are held over several cycles and changed rarely. Pushes and pops therefore land both on real full and empty transitions and on levels that are already held. Writes hit the same cycle as events often enough to exercise the case where setting takes priority over clearing.

// File: rtl/uart_evt_irq.sv
module uart_evt_irq #(
  parameter int AW          = 2,
  parameter int STATUS_ADDR = 0,
  parameter int MASK_ADDR   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_push,
  input  logic          tx_pop,
  input  logic          tx_full,
  input  logic          tx_empty,
  input  logic          rx_push,
  input  logic          rx_pop,
  input  logic          rx_full,
  input  logic          rx_empty,
  input  logic          rx_start,
  input  logic          rx_shift_pending,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_waddr,
  input  logic [5:0]    reg_wdata,
  input  logic [AW-1:0] reg_raddr,
  output logic [5:0]    reg_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] ST_A = AW'(STATUS_ADDR);
  localparam logic [AW-1:0] MK_A = AW'(MASK_ADDR);

  logic [5:0] status_q, mask_q, set_v, clr_v;
  logic       txf_q, txe_q, rxf_q, rxe_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      txf_q <= 1'b0;
      rxf_q <= 1'b0;
      txe_q <= 1'b1;
      rxe_q <= 1'b1;
    end else begin
      txf_q <= tx_full;
      rxf_q <= rx_full;
      txe_q <= tx_empty;
      rxe_q <= rx_empty;
    end

  assign set_v = {rx_start & rx_shift_pending,
                  tx_push  & tx_full  & ~txf_q,
                  tx_pop   & tx_empty & ~txe_q,
                  rx_push  & rx_full  & ~rxf_q,
                  rx_pop   & rx_empty & ~rxe_q,
                  rx_push};

  assign clr_v = (reg_we && reg_waddr == ST_A) ? reg_wdata : 6'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status_q <= 6'd0;
      mask_q   <= 6'd0;
    end else begin
      status_q <= (status_q & ~clr_v) | set_v;
      if (reg_we && reg_waddr == MK_A) mask_q <= reg_wdata;
    end

  always_comb
    if (reg_raddr == ST_A)      reg_rdata = status_q;
    else if (reg_raddr == MK_A) reg_rdata = mask_q;
    else                        reg_rdata = 6'd0;

  assign irq = |(status_q & mask_q);
endmodule

module uart_evt_irq_chk #(
  parameter int AW          = 2,
  parameter int STATUS_ADDR = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_push,
  input logic          tx_full,
  input logic          rx_push,
  input logic          rx_start,
  input logic          rx_shift_pending,
  input logic          reg_we,
  input logic [AW-1:0] reg_waddr,
  input logic [5:0]    reg_wdata,
  input logic [5:0]    status,
  input logic [5:0]    mask,
  input logic          irq
);
  localparam logic [AW-1:0] ST_A = AW'(STATUS_ADDR);

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_waddr == ST_A) |=> ((~status & $past(status)) == 6'd0));

  // R3
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && rx_shift_pending) |=> status[5]);

  // R4
  txfull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> $past(tx_push && tx_full));

  // R8
  trigger_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> status[0]);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && reg_we && reg_waddr == ST_A && reg_wdata[0]) |=> status[0]);

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_push && reg_we && reg_waddr == ST_A && reg_wdata[0]) |=> !status[0]);

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 6'd0) |-> !irq);
endmodule

bind uart_evt_irq uart_evt_irq_chk #(.AW(AW), .STATUS_ADDR(STATUS_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_full(tx_full),
  .rx_push(rx_push), .rx_start(rx_start), .rx_shift_pending(rx_shift_pending),
  .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
  .status(status_q), .mask(mask_q), .irq(irq)
);

// File: tb/test_uart_evt_irq.sv
module test_uart_evt_irq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_push = 0, tx_pop = 0, tx_full = 0, tx_empty = 0;
  logic rx_push = 0, rx_pop = 0, rx_full = 0, rx_empty = 0;
  logic rx_start = 0, rx_shift_pending = 0, reg_we = 0, irq;
  logic [1:0] reg_waddr = 0, reg_raddr = 0;
  logic [5:0] reg_wdata = 0, reg_rdata;

  int checks = 0, fails = 0;
  logic [5:0] e_st = 0, e_mk = 0;
  logic p_txf = 0, p_rxf = 0, p_txe = 1, p_rxe = 1;

  always #10 clk = ~clk;

  uart_evt_irq #(.AW(2), .STATUS_ADDR(0), .MASK_ADDR(1)) i_uart_evt_irq (.*);

  function automatic logic [5:0] next_status();
    logic [5:0] s, c;
    s = {rx_start & rx_shift_pending, tx_push & tx_full & ~p_txf,
         tx_pop & tx_empty & ~p_txe, rx_push & rx_full & ~p_rxf,
         rx_pop & rx_empty & ~p_rxe, rx_push};
    c = (reg_we && reg_waddr == 2'd0) ? reg_wdata : 6'd0;
    return (e_st & ~c) | s;
  endfunction

  function automatic logic [5:0] read_exp(input logic [1:0] a);
    return a == 2'd0 ? e_st : a == 2'd1 ? e_mk : 6'd0;
  endfunction

  task automatic chk(input string lbl, input string what, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", lbl, what, got, exp);
    end
  endtask

  task automatic observe(input string lbl);
    logic [1:0] a;
    reg_raddr = 2'd0; #1 chk(lbl, "status", reg_rdata, e_st);
    reg_raddr = 2'd1; #1 chk(lbl, "mask", reg_rdata, e_mk);
    a = 2'($urandom_range(0, 3));
    reg_raddr = a; #1 chk(lbl, "read", reg_rdata, read_exp(a));
    chk(lbl, "irq", {5'd0, irq}, {5'd0, |(e_st & e_mk)});
  endtask

  task automatic tick(input string lbl);
    logic [5:0] ns;
    ns = next_status();
    if (reg_we && reg_waddr == 2'd1) e_mk = reg_wdata;
    e_st = ns;
    p_txf = tx_full; p_rxf = rx_full; p_txe = tx_empty; p_rxe = rx_empty;
    @(negedge clk);
    observe(lbl);
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; rx_start = 0; reg_we = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    reg_we = 1; reg_waddr = a; reg_wdata = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    observe("R1 reset");
    rst_n = 1;

    rx_push = 1; tick("R8 trigger");
    wr(0, 6'h3E); tick("R2 write zero keeps bit");
    wr(0, 6'h01); tick("R2 write one clears");
    rx_push = 1; rx_full = 1; tick("R6 rx full edge");
    wr(0, 6'h3F); tick("R2 clear all");
    rx_push = 1; tick("R6 full level no retrigger");
    rx_full = 0; wr(0, 6'h3F); tick("R2 clear");
    tick("R7 prep");
    rx_pop = 1; rx_empty = 1; tick("R7 rx empty edge");
    rx_pop = 1; tick("R7 empty level no retrigger");
    tx_push = 1; tx_full = 1; tick("R4 tx full edge");
    tx_push = 1; tick("R4 full level no retrigger");
    tx_full = 0; tx_pop = 1; tx_empty = 1; tick("R5 tx empty edge");
    rx_start = 1; tick("R3 start without pending");
    rx_start = 1; rx_shift_pending = 1; tick("R3 overflow");
    rx_shift_pending = 0;
    rx_push = 1; wr(0, 6'h01); tick("R9 set beats clear");
    wr(1, 6'h01); tick("R10 mask enables trigger");
    wr(0, 6'h01); tick("R10 irq drops on clear");
    wr(2, 6'h3F); tick("R10 unmapped write");
    wr(1, 6'h00); tick("R10 mask cleared");

    for (int i = 0; i < 3000; i++) begin
      tx_push = ($urandom_range(0, 2) == 0);
      tx_pop  = ($urandom_range(0, 2) == 0);
      rx_push = ($urandom_range(0, 2) == 0);
      rx_pop  = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 5) == 0) tx_full  = ~tx_full;
      if ($urandom_range(0, 5) == 0) tx_empty = ~tx_empty;
      if ($urandom_range(0, 5) == 0) rx_full  = ~rx_full;
      if ($urandom_range(0, 5) == 0) rx_empty = ~rx_empty;
      rx_start = ($urandom_range(0, 4) == 0);
      rx_shift_pending = ($urandom_range(0, 1) == 0);
      if ($urandom_range(0, 2) == 0) wr(2'($urandom_range(0, 3)), 6'($urandom));
      tick("random R2 R3 R4 R5 R6 R7 R8 R9 R10");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule